// File: doc/BRIEF.md
# Activate Spacing Gate

This block decides, cycle by cycle, whether a row-activate command aimed at a given bank may go out on the command bus of a DDR3-style memory device. It keeps a timestamp of the most recent activate to every bank. It also keeps a short global history of the most recent activates to any bank. From these it judges a candidate activate against three spacing rules: a minimum gap to the previous activate on the same bank, a minimum gap to the previous activate on any bank, and a cap on how many activates may fall inside a rolling window.

A scheduler presents the candidate through a request line and a bank index, together with the current value of a free-running cycle counter. The block answers combinationally through an allow line. A candidate that breaks a rule, or that arrives while the command bus is busy, is refused. The scheduler simply presents it again on the next clock until it is allowed. When the scheduler actually sends an activate, it pulses the issue strobe with the bank index. The block then records that cycle into its histories at the next rising clock edge. Only activates that have already been sent are tracked, so every spacing is measured backwards from the present cycle.

Top module: `act_window_gate`

## Requirements
- R1: After reset every history slot is empty, and an empty slot never blocks, so the first request to any bank is allowed while the bus is free.
- R2: A request to bank b is refused while the cycle counter minus the cycle of the last recorded activate to bank b is below T_RC, and that rule stops refusing it from the cycle where the difference reaches T_RC.
- R3: A request to any bank is refused while the cycle counter minus the cycle of the most recent recorded activate to any bank is below T_RRD.
- R4: Once at least N_ACT activates have been recorded, a request is refused while the cycle counter minus the cycle of the N_ACT-th most recent activate is below T_FAW, so no more than N_ACT activates fall within any T_FAW window.
- R5: While fewer than N_ACT activates have been recorded since reset, the rolling-window rule refuses nothing.
- R6: The allow output is low in every cycle where bus_busy is high, and a request that is otherwise legal is allowed in the first cycle the bus is free.
- R7: The allow output is low whenever act_req is low.
- R8: Histories change only on a rising clock edge with act_issue high, recording the cycle counter value under act_bank; a request without the issue strobe leaves every spacing rule unchanged.
- R9: Asserting the active-low reset in the middle of operation clears all histories, so that R1 holds again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| act_req | input | 1 | A candidate activate is presented this cycle |
| act_bank | input | BANK_W | Bank index of the candidate and of an issued activate |
| act_issue | input | 1 | An activate to act_bank is sent this cycle |
| cycle_now | input | 32 | Free-running cycle counter value of this cycle |
| bus_busy | input | 1 | The command bus is taken this cycle |
| act_allow | output | 1 | The candidate meets every spacing rule and the bus is free |

## Verification
The rolling-window rule is the hardest to reach from the ports. It only binds once N_ACT activates to distinct banks have gone out at close to the minimum any-bank spacing, and it must bind while the same-bank and any-bank rules are already satisfied. A directed sequence after reset issues to banks 0, 1, 2 and so on at the earliest allowed cycle, so the fifth request is refused only by the window rule. The random phase issues most allowed requests, so the history stays densely packed and the window rule takes turns with the other rules as the limiting one.

// File: rtl/act_gate_pkg.sv
package act_gate_pkg;

  localparam int unsigned STAMP_W = 32;

  typedef logic [STAMP_W-1:0] stamp_t;

  typedef struct packed {
    logic   vld;
    stamp_t at;
  } stamp_rec_t;

  // An empty record counts as infinitely old.
  function automatic logic elapsed_ge(stamp_rec_t r, stamp_t now, stamp_t lim);
    return !r.vld || ((now - r.at) >= lim);
  endfunction

endpackage

// File: rtl/act_bank_hist.sv
module act_bank_hist
  import act_gate_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned T_RC      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BANK_W-1:0] bank,
  input  stamp_t            now,
  output logic              same_ok
);

  stamp_rec_t rec_q   [NUM_BANKS];
  stamp_rec_t rec_nxt [NUM_BANKS];
  logic [NUM_BANKS-1:0] wr_en;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_comb begin
      wr_en[g]   = issue && (bank == BANK_W'(g));
      rec_nxt[g] = '{vld: 1'b1, at: now};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rec_q[g] <= '0;
      else if (wr_en[g]) rec_q[g] <= rec_nxt[g];
    end
  end

  assign same_ok = elapsed_ge(rec_q[bank], now, stamp_t'(T_RC));

  // R2
  same_bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (T_RC > 1)) |=>
      ((bank != $past(bank)) || (now != $past(now) + 1'b1) || !same_ok));

endmodule

// File: rtl/act_glob_hist.sv
module act_glob_hist
  import act_gate_pkg::*;
#(
  parameter int unsigned N_ACT = 4,
  parameter int unsigned T_RRD = 4,
  parameter int unsigned T_FAW = 24
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   issue,
  input  stamp_t now,
  output logic   rrd_ok,
  output logic   faw_ok
);

  stamp_rec_t hist_q   [N_ACT];
  stamp_rec_t hist_nxt [N_ACT];
  logic [N_ACT-1:0] vld;

  for (genvar i = 0; i < N_ACT; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_comb hist_nxt[i] = '{vld: 1'b1, at: now};
    end else begin : g_tail
      always_comb hist_nxt[i] = hist_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hist_q[i] <= '0;
      else if (issue) hist_q[i] <= hist_nxt[i];
    end

    assign vld[i] = hist_q[i].vld;
  end

  assign rrd_ok = elapsed_ge(hist_q[0], now, stamp_t'(T_RRD));
  assign faw_ok = elapsed_ge(hist_q[N_ACT-1], now, stamp_t'(T_FAW));

  // R3
  any_bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (T_RRD > 1)) |=> ((now != $past(now) + 1'b1) || !rrd_ok));

  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) <= $past($countones(vld)) + 1);

  // R4
  window_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vld[N_ACT-1]) |-> vld[N_ACT-1]);

endmodule

// File: rtl/act_window_gate.sv
module act_window_gate
  import act_gate_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned N_ACT     = 4,
  parameter int unsigned T_RC      = 20,
  parameter int unsigned T_RRD     = 4,
  parameter int unsigned T_FAW     = 24,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_req,
  input  logic [BANK_W-1:0]          act_bank,
  input  logic                       act_issue,
  input  logic [STAMP_W-1:0]         cycle_now,
  input  logic                       bus_busy,
  output logic                       act_allow
);

  logic same_ok;
  logic rrd_ok;
  logic faw_ok;

  act_bank_hist #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .T_RC      (T_RC)
  ) u_bank_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (act_issue),
    .bank    (act_bank),
    .now     (cycle_now),
    .same_ok (same_ok)
  );

  act_glob_hist #(
    .N_ACT (N_ACT),
    .T_RRD (T_RRD),
    .T_FAW (T_FAW)
  ) u_glob_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (act_issue),
    .now    (cycle_now),
    .rrd_ok (rrd_ok),
    .faw_ok (faw_ok)
  );

  assign act_allow = act_req && !bus_busy && same_ok && rrd_ok && faw_ok;

  // R6
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !act_allow);

  // R7
  req_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_allow |-> act_req);

endmodule

// File: tb/act_window_gate_bench.sv
module act_window_gate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 8;
  localparam int N    = 4;
  localparam int TRC  = 20;
  localparam int TRRD = 4;
  localparam int TFAW = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        act_req;
  logic [2:0]  act_bank;
  logic        act_issue;
  logic [31:0] cycle_now;
  logic        bus_busy;
  logic        act_allow;

  int nchk  = 0;
  int nfail = 0;
  int unsigned now_c = 100;

  bit          bvld [NB];
  int unsigned bat  [NB];
  bit          hv   [N];
  int unsigned hat  [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  act_window_gate #(
    .NUM_BANKS (NB), .N_ACT (N), .T_RC (TRC), .T_RRD (TRRD), .T_FAW (TFAW)
  ) u_act_window_gate (
    .clk (clk), .rst_n (rst_n), .act_req (act_req), .act_bank (act_bank),
    .act_issue (act_issue), .cycle_now (cycle_now), .bus_busy (bus_busy),
    .act_allow (act_allow)
  );

  function automatic bit exp_allow(bit req, int bank, bit busy, int unsigned now);
    if (!req || busy) return 1'b0;
    if (bvld[bank] && (now - bat[bank]) < TRC) return 1'b0;
    if (hv[0] && (now - hat[0]) < TRRD) return 1'b0;
    if (hv[N-1] && (now - hat[N-1]) < TFAW) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin bvld[b] = 0; bat[b] = 0; end
    for (int i = 0; i < N; i++)  begin hv[i] = 0;   hat[i] = 0; end
  endtask

  task automatic model_issue(int bank, int unsigned now);
    bvld[bank] = 1; bat[bank] = now;
    for (int i = N-1; i > 0; i--) begin hv[i] = hv[i-1]; hat[i] = hat[i-1]; end
    hv[0] = 1; hat[0] = now;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; act_req = 0; act_issue = 0; bus_busy = 0; act_bank = 0;
    cycle_now = now_c;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic step(bit req, int bank, bit busy, bit want, string tag, output bit got);
    bit e;
    @(negedge clk);
    act_req = req; act_bank = 3'(bank); bus_busy = busy; act_issue = 0;
    cycle_now = now_c;
    #1;
    e = exp_allow(req, bank, busy, now_c);
    nchk++;
    if (act_allow !== e) begin
      nfail++;
      $display("FAIL %s: cycle %0d bank %0d allow actual %b expected %b",
               tag, now_c, bank, act_allow, e);
    end
    act_issue = want && e;
    got = act_issue;
    @(posedge clk);
    if (got) model_issue(bank, now_c);
    now_c++;
    #1 act_issue = 0;
  endtask

  task automatic push_until_issued(int bank, string tag);
    bit got = 0;
    for (int k = 0; k < 200 && !got; k++) step(1, bank, 0, 1, tag, got);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: run actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    bit g;
    void'($urandom(32'h5eed));
    model_clear();
    do_reset();

    // R7: no request, no allow; R1: first activate free after reset
    step(0, 3, 0, 0, "R7", g);
    step(1, 3, 0, 1, "R1", g);

    // R2: same bank retried until T_RC elapsed
    for (int k = 0; k < TRC + 2; k++) step(1, 3, 0, 1, "R2", g);

    // R3: other banks right after an issue
    push_until_issued(5, "R3");
    for (int k = 0; k < TRRD + 1; k++) step(1, 6, 0, 0, "R3", g);

    // R8: request without strobe records nothing
    repeat (TRC) step(0, 0, 0, 0, "R8", g);
    step(1, 1, 0, 0, "R8", g);
    step(1, 2, 0, 0, "R8", g);
    step(1, 1, 0, 0, "R8", g);

    // R6: bus busy holds a legal request off
    for (int k = 0; k < 5; k++) step(1, 7, 1, 1, "R6", g);
    step(1, 7, 0, 1, "R6", g);

    // R5 then R4: pack N activates, window then binds
    do_reset();
    for (int b = 0; b < N; b++) push_until_issued(b, "R5");
    for (int k = 0; k < TFAW; k++) step(1, N, 0, 1, "R4", g);
    push_until_issued(N + 1, "R4");

    // R9: reset mid-run clears history
    push_until_issued(2, "R9");
    do_reset();
    step(1, 2, 0, 0, "R9", g);
    step(1, 3, 0, 1, "R9", g);
    step(1, 3, 0, 0, "R9", g);

    // Random mix covering R2, R3, R4, R6, R7
    for (int k = 0; k < 5000; k++) begin
      if (($urandom % 700) == 0) do_reset();
      step(($urandom % 4) != 0, int'($urandom % NB), ($urandom % 5) == 0,
           ($urandom % 4) != 0, "R2/R3/R4/R6/R7", g);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule